// File: doc/BRIEF.md
# BCD Calendar Clock Register Window

This block keeps a calendar clock in packed BCD: seconds, minutes, hours, day of week, date, month and year. A 1 Hz tick enable advances the count. Software sees the clock through eight byte registers that occupy the top eight addresses of a byte-addressed space, and it reaches them over a synchronous bus with address, write enable, write data and registered read data.

The software-visible bytes are holding copies of the internal counters. They are not the counters themselves. One control bit freezes the copies so that a multi-byte read is coherent while the counters keep running. A second control bit freezes the copies and stops counting so that software can load a new time. Clearing that second bit moves the loaded bytes into the counters. A stop bit in the seconds byte keeps the clock from advancing. That bit is set at reset.

Top module: `bcd_rtc_window`

## Requirements
- R1: The window covers the eight addresses whose upper address bits are all ones. The offset `addr_i[2:0]` selects the byte as follows: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. A read outside the window returns 0x00, and a write outside the window changes nothing.
- R2: `rdata_o` presents the byte selected by the address one clock after that address is presented.
- R3: When both halt bits are 0, each holding byte takes the counter value of the previous cycle. Writes to time bytes then have no lasting effect.
- R4: Writing 1 to control bit 6 freezes the holding bytes at the count copied in that same cycle. The counters keep advancing. After the bit is written back to 0, the holding bytes show the advanced count.
- R5: Writing 1 to control bit 7 freezes the holding bytes and suppresses ticks. While the bit is set, software writes land in the holding bytes. Writing 0 to the bit copies the year-through-seconds bytes into the counters.
- R6: Seconds bit 7 is a stop flag. It reads 1 after reset, and no tick advances the clock while it is 1.
- R7: After a load through control bit 7, and after the stop flag goes from 1 to 0, the first tick is absorbed. The count then advances on the second tick.
- R8: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. The day of week counts 1 to 7 and goes back to 1 at each midnight.
- R9: The date goes back to 01 after 31, 30, 28 or 29 days, depending on the month. A year divisible by 4 is a leap year. December moves to January, and the year wraps from 99 to 00.
- R10: Unused bits read as 0. The readable fields are: month bits 4:0, date bits 5:0, hours bits 5:0, minutes bits 6:0, and day bits 2:0. Bit 6 of the day byte is a stored flag that reads back as written. Control bits 5:0 read as 0.
- R11: Reset gives 00:00:00, day 1, date 01, month 01, year 00, control 0x00 and stop flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
A tick and a write that sets the read-halt bit can occur in the same clock. The bench provokes this by driving `tick_i` and the control write in the same cycle. It then expects the frozen seconds byte to hold the count from before the tick. After the halt is released, it expects the seconds byte to show the advanced count, because the counters kept running. End-of-month and end-of-day rollovers are swept over every month and over several leap and non-leap years. Each expected value is computed in binary and converted to BCD.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] mins;
    logic [7:0] secs;
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                       dow: 8'h01, hr: 8'h00, mins: 8'h00, secs: 8'h00};

  localparam logic [7:0] MASK_SEC  = 8'h7F;
  localparam logic [7:0] MASK_MIN  = 8'h7F;
  localparam logic [7:0] MASK_HR   = 8'h3F;
  localparam logic [7:0] MASK_DOW  = 8'h07;
  localparam logic [7:0] MASK_DATE = 8'h3F;
  localparam logic [7:0] MASK_MON  = 8'h1F;

  typedef enum logic [2:0] {
    OFF_CTL  = 3'd0,
    OFF_SEC  = 3'd1,
    OFF_MIN  = 3'd2,
    OFF_HR   = 3'd3,
    OFF_DOW  = 3'd4,
    OFF_DATE = 3'd5,
    OFF_MON  = 3'd6,
    OFF_YR   = 3'd7
  } rtc_off_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*t + o is divisible by 4 when 2*t[0] + o[1:0] is 0 mod 4
  function automatic logic is_leap(input logic [7:0] yr);
    logic [1:0] s;
    s = {yr[4], 1'b0} + yr[1:0];
    return (s == 2'd0);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t next_time(input rtc_time_t t);
    rtc_time_t n;
    logic c;
    n = t;
    c = (t.secs == 8'h59);
    n.secs = c ? 8'h00 : bcd_inc(t.secs);
    if (c) begin
      c = (t.mins == 8'h59);
      n.mins = c ? 8'h00 : bcd_inc(t.mins);
    end
    if (c) begin
      c = (t.hr == 8'h23);
      n.hr = c ? 8'h00 : bcd_inc(t.hr);
    end
    if (c) begin
      n.dow  = (t.dow == 8'h07) ? 8'h01 : t.dow + 8'h01;
      c      = (t.date == month_last(t.mon, t.yr));
      n.date = c ? 8'h01 : bcd_inc(t.date);
    end
    if (c) begin
      c     = (t.mon == 8'h12);
      n.mon = c ? 8'h01 : bcd_inc(t.mon);
    end
    if (c) n.yr = (t.yr == 8'h99) ? 8'h00 : bcd_inc(t.yr);
    return n;
  endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      stop_i,
  input  logic      wrh_i,
  input  logic      load_i,
  input  logic      start_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cnt_o
);

  rtc_time_t cnt_q;
  logic      skip_q;
  logic      run;

  assign run = tick_i && !stop_i && !wrh_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RESET_TIME;
      skip_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      skip_q <= 1'b1;
    end else if (start_i) begin
      skip_q <= 1'b1;
    end else if (run) begin
      if (skip_q) skip_q <= 1'b0;
      else        cnt_q  <= next_time(cnt_q);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rtc_hold_regs.sv
module rtc_hold_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  rtc_time_t         cnt_i,
  output rtc_time_t         hold_o,
  output logic              stop_o,
  output logic              wrh_o,
  output logic              rdh_o,
  output logic              load_o,
  output logic              start_o,
  output logic [7:0]        rdata_o
);

  localparam int OFF_W = 3;

  rtc_time_t  hold_q, hold_d;
  logic       stop_q, wrh_q, rdh_q, ft_q;
  logic       in_win, wr_en;
  rtc_off_e   off;
  logic [7:0] rd_d, rdata_q;

  assign in_win = &addr_i[ADDR_W-1:OFF_W];
  assign wr_en  = we_i && in_win;
  assign off    = rtc_off_e'(addr_i[OFF_W-1:0]);

  assign load_o  = wr_en && (off == OFF_CTL) && wrh_q && !wdata_i[7];
  assign start_o = wr_en && (off == OFF_SEC) && stop_q && !wdata_i[7];

  always_comb begin
    hold_d = hold_q;
    if (!(wrh_q || rdh_q)) hold_d = cnt_i;
    if (wr_en) begin
      case (off)
        OFF_SEC:  hold_d.secs = wdata_i & MASK_SEC;
        OFF_MIN:  hold_d.mins = wdata_i & MASK_MIN;
        OFF_HR:   hold_d.hr   = wdata_i & MASK_HR;
        OFF_DOW:  hold_d.dow  = wdata_i & MASK_DOW;
        OFF_DATE: hold_d.date = wdata_i & MASK_DATE;
        OFF_MON:  hold_d.mon  = wdata_i & MASK_MON;
        OFF_YR:   hold_d.yr   = wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= RESET_TIME;
      stop_q <= 1'b1;
      wrh_q  <= 1'b0;
      rdh_q  <= 1'b0;
      ft_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      if (wr_en && off == OFF_CTL) begin
        wrh_q <= wdata_i[7];
        rdh_q <= wdata_i[6];
      end
      if (wr_en && off == OFF_SEC) stop_q <= wdata_i[7];
      if (wr_en && off == OFF_DOW) ft_q   <= wdata_i[6];
    end
  end

  always_comb begin
    rd_d = 8'h00;
    if (in_win) begin
      case (off)
        OFF_CTL:  rd_d = {wrh_q, rdh_q, 6'b0};
        OFF_SEC:  rd_d = {stop_q, hold_q.secs[6:0]};
        OFF_MIN:  rd_d = hold_q.mins;
        OFF_HR:   rd_d = hold_q.hr;
        OFF_DOW:  rd_d = {1'b0, ft_q, hold_q.dow[5:0]};
        OFF_DATE: rd_d = hold_q.date;
        OFF_MON:  rd_d = hold_q.mon;
        OFF_YR:   rd_d = hold_q.yr;
        default:  rd_d = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= 8'h00;
    else         rdata_q <= rd_d;
  end

  assign hold_o  = hold_q;
  assign stop_o  = stop_q;
  assign wrh_o   = wrh_q;
  assign rdh_o   = rdh_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/bcd_rtc_window.sv
module bcd_rtc_window
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  rtc_time_t cnt_w, hold_w;
  logic      stop_w, wrh_w, rdh_w, load_w, start_w;

  rtc_hold_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .cnt_i   (cnt_w),
    .hold_o  (hold_w),
    .stop_o  (stop_w),
    .wrh_o   (wrh_w),
    .rdh_o   (rdh_w),
    .load_o  (load_w),
    .start_o (start_w),
    .rdata_o (rdata_o)
  );

  rtc_time_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .stop_i     (stop_w),
    .wrh_i      (wrh_w),
    .load_i     (load_w),
    .start_i    (start_w),
    .load_val_i (hold_w),
    .cnt_o      (cnt_w)
  );

endmodule

// File: rtl/rtc_window_chk.sv
module rtc_window_chk
  import rtc_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      tick_i,
  input logic      we_i,
  input rtc_time_t cnt_w,
  input rtc_time_t hold_w,
  input logic      stop_w,
  input logic      wrh_w,
  input logic      rdh_w,
  input logic      load_w
);

  a_r3_follow_counter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdh_w && !wrh_w && !we_i) |=> (hold_w == $past(cnt_w)));

  a_r4_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdh_w || wrh_w) && !we_i) |=> $stable(hold_w));

  a_r5_load_copies_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> (cnt_w == $past(hold_w)));

  a_r5_no_count_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrh_w && !load_w) |=> $stable(cnt_w));

  a_r6_stop_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_w && !load_w) |=> $stable(cnt_w));

  a_r7_no_tick_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_w) |=> $stable(cnt_w));

endmodule

bind bcd_rtc_window rtc_window_chk u_chk (.*);

// File: tb/bcd_rtc_window_test.sv
module bcd_rtc_window_test;

  localparam int AW = 17;
  localparam logic [AW-1:0] WIN = 17'h1FFF8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [7:0]    wdata = 8'h00;
  logic [7:0]    rdata;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bcd_rtc_window #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic logic [55:0] pack(input int y, mo, d, dw, h, mi, s);
    return {bcd(y), bcd(mo), bcd(d), bcd(dw), bcd(h), bcd(mi), bcd(s)};
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [55:0] act, input logic [55:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic tk = 1'b0);
    addr = a; wdata = d; we = 1'b1; tick = tk;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    addr = a; we = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_all(output logic [55:0] v);
    logic [7:0] b;
    for (int i = 7; i >= 1; i--) begin
      rd(WIN | AW'(i), b);
      v[(i-1)*8 +: 8] = b;
    end
  endtask

  task automatic set_time(input int y, mo, d, dw, h, mi, s);
    wr(WIN | 0, 8'h80);
    wr(WIN | 7, bcd(y));
    wr(WIN | 6, bcd(mo));
    wr(WIN | 5, bcd(d));
    wr(WIN | 4, bcd(dw));
    wr(WIN | 3, bcd(h));
    wr(WIN | 2, bcd(mi));
    wr(WIN | 1, bcd(s));
    wr(WIN | 0, 8'h00);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [55:0] v;
    int ys[10] = '{0, 1, 2, 3, 4, 8, 12, 96, 97, 99};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 / R6: reset state
    rd(WIN | 0, b); check("R11 ctl", 56'(b), 56'h00);
    rd(WIN | 1, b); check("R6 stop at reset", 56'(b), 56'h80);
    rd_all(v);      check("R11 time", v, {pack(0, 1, 1, 1, 0, 0, 0)} | 56'h80);

    // R6: ticks ignored while stopped
    repeat (3) do_tick();
    rd(WIN | 1, b); check("R6 stopped", 56'(b), 56'h80);

    // R7: clear stop, first tick absorbed
    wr(WIN | 1, 8'h00);
    do_tick();
    rd(WIN | 1, b); check("R7 absorbed after start", 56'(b), 56'h00);
    do_tick();
    rd(WIN | 1, b); check("R7 second tick advances", 56'(b), 56'h01);
    do_tick();
    rd(WIN | 1, b); check("R3 follows counter", 56'(b), 56'h02);

    // R2: read latency, address changed every cycle
    addr = WIN | 1; @(negedge clk);
    addr = WIN | 6; b = rdata; @(negedge clk);
    check("R2 latency sec", 56'(b), 56'h02);
    b = rdata; check("R2 latency mon", 56'(b), 56'h01);

    // R4: read halt, counters keep going
    wr(WIN | 0, 8'h40);
    repeat (3) do_tick();
    rd(WIN | 1, b); check("R4 frozen", 56'(b), 56'h02);
    rd(WIN | 0, b); check("R4 ctl readback", 56'(b), 56'h40);
    wr(WIN | 0, 8'h00);
    rd(WIN | 1, b); check("R4 resumed", 56'(b), 56'h05);

    // R4: halt write and tick in the same cycle
    wr(WIN | 0, 8'h40, 1'b1);
    rd(WIN | 1, b); check("R4 same-cycle frozen pre-tick", 56'(b), 56'h05);
    wr(WIN | 0, 8'h00);
    rd(WIN | 1, b); check("R4 same-cycle tick counted", 56'(b), 56'h06);

    // R3: writes without halt have no lasting effect
    wr(WIN | 2, 8'h33);
    rd(WIN | 2, b); check("R3 write overwritten", 56'(b), 56'h00);

    // R1: out-of-window access
    rd(17'h00001, b); check("R1 outside read", 56'(b), 56'h00);
    wr(17'h1FFF1, 8'h80);
    do_tick();
    rd(WIN | 1, b); check("R1 outside write ignored", 56'(b), 56'h07);

    // R5: write halt suppresses ticks, release loads
    wr(WIN | 0, 8'h80);
    repeat (2) do_tick();
    wr(WIN | 2, 8'h45);
    rd(WIN | 2, b); check("R5 hold accepts write", 56'(b), 56'h45);
    wr(WIN | 0, 8'h00);
    rd(WIN | 1, b); check("R5 no count during write halt", 56'(b), 56'h07);
    rd(WIN | 2, b); check("R5 loaded minutes", 56'(b), 56'h45);
    do_tick();
    rd(WIN | 1, b); check("R7 absorbed after load", 56'(b), 56'h07);
    do_tick();
    rd(WIN | 1, b); check("R7 advances after load", 56'(b), 56'h08);

    // R10: masks and flag bit
    wr(WIN | 0, 8'h80);
    wr(WIN | 6, 8'hFF); rd(WIN | 6, b); check("R10 month mask", 56'(b), 56'h1F);
    wr(WIN | 5, 8'hFF); rd(WIN | 5, b); check("R10 date mask", 56'(b), 56'h3F);
    wr(WIN | 3, 8'hFF); rd(WIN | 3, b); check("R10 hours mask", 56'(b), 56'h3F);
    wr(WIN | 2, 8'hFF); rd(WIN | 2, b); check("R10 minutes mask", 56'(b), 56'h7F);
    wr(WIN | 4, 8'hFF); rd(WIN | 4, b); check("R10 day mask and flag", 56'(b), 56'h47);
    wr(WIN | 4, 8'h01); rd(WIN | 4, b); check("R10 flag cleared", 56'(b), 56'h01);
    wr(WIN | 0, 8'hFF); rd(WIN | 0, b); check("R10 ctl low bits", 56'(b), 56'hC0);

    // R8: continuous seconds/minutes/hours sweep
    set_time(5, 3, 10, 2, 0, 58, 30);
    do_tick();
    begin
      int s = 30, mi = 58, h = 0;
      for (int k = 0; k < 100; k++) begin
        do_tick();
        s++;
        if (s == 60) begin s = 0; mi++; end
        if (mi == 60) begin mi = 0; h++; end
        rd(WIN | 1, v[7:0]); rd(WIN | 2, v[15:8]); rd(WIN | 3, v[23:16]);
        check("R8 sec/min/hr sweep", 56'(v[23:0]), 56'({bcd(h), bcd(mi), bcd(s)}));
      end
    end

    // R8: hour wrap inside the day, day-of-week wrap
    set_time(20, 5, 10, 3, 9, 59, 59); do_tick(); do_tick();
    rd_all(v); check("R8 hour carry", v, pack(20, 5, 10, 3, 10, 0, 0));
    set_time(20, 5, 10, 7, 23, 59, 59); do_tick(); do_tick();
    rd_all(v); check("R8 dow 7 to 1", v, pack(20, 5, 11, 1, 0, 0, 0));

    // R9: end-of-month sweep over months and years
    foreach (ys[i]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int y = ys[i];
        int dw = (mo % 7) + 1;
        set_time(y, mo, mdays(mo, y), dw, 23, 59, 59);
        do_tick(); do_tick();
        rd_all(v);
        check("R9 month end", v,
              pack((mo == 12) ? (y + 1) % 100 : y, (mo % 12) + 1, 1, (dw % 7) + 1, 0, 0, 0));
      end
      set_time(ys[i], 2, 28, 4, 23, 59, 59);
      do_tick(); do_tick();
      rd_all(v);
      check("R9 Feb 28 leap rule", v,
            (ys[i] % 4 == 0) ? pack(ys[i], 2, 29, 5, 0, 0, 0) : pack(ys[i], 3, 1, 5, 0, 0, 0));
    end

    finish_run();
  end

endmodule